// File: doc/BRIEF.md
# Program Image Checksum Engine

This engine produces the 16-bit verification checksum of a device image held in a word-addressed memory. After a start pulse it first fetches the configuration word from the top of the selected address space and reads its protection bit. That bit decides what is summed next. With protection off, every user location except the topmost one is added. With protection on, only the low 64 locations are added, together with a packed value built from the four identification words. In both cases the configuration word, masked to its five low bits, is also added. All additions wrap at 16 bits.

A variant input selects between a 1K-word space (user area 0x000–0x1FF, ID words at 0x200–0x203, configuration word at 0x3FF) and a 2K-word space (user area 0x000–0x3FF, ID words at 0x400–0x403, configuration word at 0x7FF). The engine issues at most one read per clock. Read data returns one cycle later. A one-cycle done pulse marks the result as valid.

Top module: `pgm_csum`

## Requirements
- R1: After reset, done_o and mem_rd_o are 0 and result_o is 0x0000. While idle, the engine issues no reads.
- R2: The first read after an accepted start targets the configuration word: address 0x3FF when large_i was 0 at start, 0x7FF when it was 1. The variant is latched at start, and later changes of large_i have no effect on the running pass.
- R3: The checksum is the sum of its terms modulo 2^16. Carries out of bit 15 are dropped.
- R4: When bit 3 of the configuration word is 1 (unprotected), the sum covers locations 0x000 up to 0x1FE (small) or 0x3FE (large), plus the configuration word ANDed with 0x01F. An all-ones small image gives 0xEE20 and an all-ones large image gives 0xEC20.
- R5: When bit 3 of the configuration word is 0 (protected), the sum covers only locations 0x000–0x03F, plus the masked configuration word, plus the ID term.
- R6: The ID term is 16 bits wide and is built from bits 3:0 of the four ID words. The lowest-addressed ID word supplies bits 15:12 and the highest supplies bits 3:0, so IDs 1,2,3,4 give 0x1234.
- R7: Reads are issued on consecutive cycles, and scan addresses rise by one each cycle. done_o rises exactly 3+N clock edges after the edge that samples the start. N is 0x1FF (small) or 0x3FF (large) when unprotected, and 68 when protected.
- R8: done_o is high for exactly one cycle per pass.
- R9: A start pulse while a pass is running is ignored. It changes neither the timing nor the result of that pass.
- R10: result_o changes only in the cycle done_o is high, and holds between passes.
- R11: No read is issued outside the configuration word, the summed range and, when protected, the four ID words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a pass (one-cycle pulse, taken when idle) |
| large_i | input | 1 | Variant select: 0 = 1K space, 1 = 2K space |
| mem_rd_o | output | 1 | Read strobe for the image memory |
| mem_addr_o | output | ADDR_W (11) | Read address |
| mem_data_i | input | WORD_W (12) | Read data, valid one cycle after the strobe |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | SUM_W (16) | Checksum result |

## Verification
The bench builds the engine with its default widths: an 11-bit address, 12-bit words and a 16-bit sum. With these widths both variants run at their full scan length, and the sums pass 2^16 many times, so the wrap can be seen. A behavioural memory answers reads with one cycle of latency. Images cover the all-ones blank cases, a protected image whose result is just the packed ID value, and address-derived patterns in both protection states. One pass receives a second start and a flipped variant select part-way through.

// File: rtl/pgm_csum_pkg.sv
package pgm_csum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CFG, ST_CFGW, ST_ID, ST_SCAN, ST_DRAIN
  } seq_st_e;

  // tag of the read whose data is on the bus this cycle
  typedef enum logic [1:0] {
    RK_NONE, RK_CFG, RK_ID, RK_SCAN
  } rd_kind_e;
endpackage

// File: rtl/pgm_csum_seq.sv
module pgm_csum_seq
  import pgm_csum_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ID_N      = 4,
  parameter int ID_IW     = 2,
  parameter int PROT_LAST = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              large_i,
  input  logic              cp_bit_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output rd_kind_e          kind_o,
  output logic [ID_IW-1:0]  idx_o,
  output logic              busy_o,
  output logic              scan_o,
  output logic              fin_o
);
  localparam logic [ADDR_W-1:0] CFG_BIG   = '1;
  localparam logic [ADDR_W-1:0] CFG_SMALL = CFG_BIG >> 1;
  localparam logic [ADDR_W-1:0] ID_BIG    = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] ID_SMALL  = ID_BIG >> 1;
  localparam logic [ADDR_W-1:0] PROT_END  = ADDR_W'(PROT_LAST);
  localparam logic [ADDR_W-1:0] ID_END    = ADDR_W'(ID_N - 1);

  seq_st_e           st_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              large_q, prot_q;
  rd_kind_e          kind_q;
  logic [ID_IW-1:0]  idx_q;

  logic [ADDR_W-1:0] cfg_addr, id_base, user_end, scan_end;

  always_comb begin
    cfg_addr = large_q ? CFG_BIG : CFG_SMALL;
    id_base  = large_q ? ID_BIG : ID_SMALL;
    user_end = id_base - ADDR_W'(2);
    scan_end = prot_q ? PROT_END : user_end;
  end

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_addr_o = '0;
    unique case (st_q)
      ST_CFG:  begin mem_rd_o = 1'b1; mem_addr_o = cfg_addr;        end
      ST_ID:   begin mem_rd_o = 1'b1; mem_addr_o = id_base + cnt_q; end
      ST_SCAN: begin mem_rd_o = 1'b1; mem_addr_o = cnt_q;           end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      large_q <= 1'b0;
      prot_q  <= 1'b0;
      kind_q  <= RK_NONE;
      idx_q   <= '0;
    end else begin
      kind_q <= RK_NONE;
      idx_q  <= cnt_q[ID_IW-1:0];
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          large_q <= large_i;
          st_q    <= ST_CFG;
        end
        ST_CFG: begin
          kind_q <= RK_CFG;
          st_q   <= ST_CFGW;
        end
        ST_CFGW: begin
          // config data is on the bus now; bit low means protected
          prot_q <= !cp_bit_i;
          cnt_q  <= '0;
          st_q   <= cp_bit_i ? ST_SCAN : ST_ID;
        end
        ST_ID: begin
          kind_q <= RK_ID;
          if (cnt_q == ID_END) begin
            cnt_q <= '0;
            st_q  <= ST_SCAN;
          end else begin
            cnt_q <= cnt_q + ADDR_W'(1);
          end
        end
        ST_SCAN: begin
          kind_q <= RK_SCAN;
          if (cnt_q == scan_end) st_q <= ST_DRAIN;
          else                   cnt_q <= cnt_q + ADDR_W'(1);
        end
        ST_DRAIN: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign kind_o = kind_q;
  assign idx_o  = idx_q;
  assign busy_o = (st_q != ST_IDLE);
  assign scan_o = (st_q == ST_SCAN);
  assign fin_o  = (st_q == ST_DRAIN);
endmodule

// File: rtl/pgm_csum_acc.sv
module pgm_csum_acc
  import pgm_csum_pkg::*;
#(
  parameter int          WORD_W   = 12,
  parameter int          SUM_W    = 16,
  parameter int          ID_N     = 4,
  parameter int          ID_IW    = 2,
  parameter int          NIB_W    = 4,
  parameter logic [15:0] CFG_MASK = 16'h001F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  rd_kind_e          kind_i,
  input  logic [ID_IW-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              fin_i,
  output logic              done_o,
  output logic [SUM_W-1:0]  result_o
);
  localparam logic [SUM_W-1:0] MASK_S = SUM_W'(CFG_MASK);

  logic [SUM_W-1:0] id_term [ID_N];
  logic [SUM_W-1:0] addend, acc_q, acc_nxt, res_q;
  logic             done_q;

  // first ID word lands in the top nibble
  for (genvar g = 0; g < ID_N; g++) begin : g_id_pos
    assign id_term[g] = SUM_W'(data_i[NIB_W-1:0]) << (NIB_W * (ID_N - 1 - g));
  end

  always_comb begin
    unique case (kind_i)
      RK_CFG:  addend = SUM_W'(data_i) & MASK_S;
      RK_ID:   addend = id_term[idx_i];
      RK_SCAN: addend = SUM_W'(data_i);
      default: addend = '0;
    endcase
    acc_nxt = acc_q + addend;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= clr_i ? '0 : acc_nxt;
      done_q <= fin_i;
      if (fin_i) res_q <= acc_nxt;
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/pgm_csum.sv
module pgm_csum
  import pgm_csum_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          WORD_W    = 12,
  parameter int          SUM_W     = 16,
  parameter int          ID_N      = 4,
  parameter int          NIB_W     = 4,
  parameter int          PROT_LAST = 63,
  parameter int          CP_BIT    = 3,
  parameter logic [15:0] CFG_MASK  = 16'h001F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              large_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              done_o,
  output logic [SUM_W-1:0]  result_o
);
  localparam int ID_IW = (ID_N > 1) ? $clog2(ID_N) : 1;

  rd_kind_e         kind;
  logic [ID_IW-1:0] idx;
  logic             busy, scan, fin, start_ok;

  assign start_ok = start_i && !busy;

  pgm_csum_seq #(
    .ADDR_W(ADDR_W), .ID_N(ID_N), .ID_IW(ID_IW), .PROT_LAST(PROT_LAST)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .large_i    (large_i),
    .cp_bit_i   (mem_data_i[CP_BIT]),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .kind_o     (kind),
    .idx_o      (idx),
    .busy_o     (busy),
    .scan_o     (scan),
    .fin_o      (fin)
  );

  pgm_csum_acc #(
    .WORD_W(WORD_W), .SUM_W(SUM_W), .ID_N(ID_N), .ID_IW(ID_IW),
    .NIB_W(NIB_W), .CFG_MASK(CFG_MASK)
  ) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok),
    .kind_i   (kind),
    .idx_i    (idx),
    .data_i   (mem_data_i),
    .fin_i    (fin),
    .done_o   (done_o),
    .result_o (result_o)
  );
endmodule

// File: rtl/pgm_csum_chk.sv
module pgm_csum_chk #(
  parameter int ADDR_W = 11,
  parameter int SUM_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              large_i,
  input logic              busy_i,
  input logic              scan_i,
  input logic              mem_rd_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              done_i,
  input logic [SUM_W-1:0]  result_i
);
  localparam logic [ADDR_W-1:0] CFG_HI = '1;
  localparam logic [ADDR_W-1:0] CFG_LO = CFG_HI >> 1;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_rd_i);

  p_first_rd_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && !busy_i) |->
      (mem_rd_i && mem_addr_i == ($past(large_i) ? CFG_HI : CFG_LO)));

  p_scan_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i && $past(scan_i)) |-> mem_addr_i == $past(mem_addr_i) + ADDR_W'(1));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_i) |-> done_i);
endmodule

bind pgm_csum pgm_csum_chk #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .large_i    (large_i),
  .busy_i     (busy),
  .scan_i     (scan),
  .mem_rd_i   (mem_rd_o),
  .mem_addr_i (mem_addr_o),
  .done_i     (done_o),
  .result_i   (result_o)
);

// File: tb/pgm_csum_tb.sv
`timescale 1ns/1ps
module pgm_csum_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        large_i = 1'b0;
  logic        mem_rd_o;
  logic [10:0] mem_addr_o;
  logic [11:0] mem_data_i = '0;
  logic        done_o;
  logic [15:0] result_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [11:0] mem [2048];

  // model state
  bit          m_busy = 0;
  bit          m_lg = 0;
  bit          m_prot = 0;
  int          m_done_cyc = 0;
  int          m_n = 0;
  int          m_rd_cnt = 0;
  logic [15:0] m_exp = '0;

  always #10 clk_i = ~clk_i;

  pgm_csum u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .large_i(large_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .done_o(done_o), .result_o(result_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (mem_rd_o) mem_data_i <= mem[mem_addr_o];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int cfg_at(input bit lg);
    return lg ? 2047 : 1023;
  endfunction

  function automatic int id_at(input bit lg);
    return lg ? 1024 : 512;
  endfunction

  function automatic logic [15:0] ref_sum(input bit lg);
    int s = 0;
    int ib = id_at(lg);
    logic [11:0] cw = mem[cfg_at(lg)];
    if (cw[3]) begin
      for (int a = 0; a <= ib - 2; a++) s += int'(mem[a]);
    end else begin
      for (int a = 0; a < 64; a++) s += int'(mem[a]);
      s += int'({mem[ib][3:0], mem[ib+1][3:0], mem[ib+2][3:0], mem[ib+3][3:0]});
    end
    s += int'(cw & 12'h01F);
    return 16'(s);
  endfunction

  function automatic bit legal(input int a);
    int ib = id_at(m_lg);
    if (a == cfg_at(m_lg)) return 1;
    if (m_prot) return (a < 64) || (a >= ib && a < ib + 4);
    return a <= ib - 2;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_rd_o) begin
        m_rd_cnt++;
        chk(m_busy, "R1 read while idle", 1, 0);
        chk(legal(int'(mem_addr_o)), "R11 read address", int'(mem_addr_o), 0);
      end
      if (m_busy && cyc == m_done_cyc) begin
        chk(done_o == 1'b1, "R7 done timing", int'(done_o), 1);
        chk(result_o == m_exp, "R3/R4/R5 result", int'(result_o), int'(m_exp));
        chk(m_rd_cnt == m_n + 1, "R7 read count", m_rd_cnt, m_n + 1);
        m_busy = 0;
      end else begin
        chk(done_o == 1'b0, "R8 done outside its cycle", int'(done_o), 0);
      end
    end
  end

  task automatic run(input bit lg, input bit poke);
    @(negedge clk_i);
    m_lg       = lg;
    m_prot     = !mem[cfg_at(lg)][3];
    m_n        = m_prot ? 68 : id_at(lg) - 1;
    m_exp      = ref_sum(lg);
    m_rd_cnt   = 0;
    m_done_cyc = cyc + 4 + m_n;
    m_busy     = 1;
    large_i    = lg;
    start_i    = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk_i);
      // R9: second start mid-pass, R2: variant flip mid-pass
      start_i = 1'b1;
      large_i = ~lg;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (cyc <= m_done_cyc) @(negedge clk_i);
  endtask

  task automatic hold_check(input logic [15:0] exp);
    repeat (5) @(negedge clk_i);
    large_i = ~large_i;
    repeat (3) @(negedge clk_i);
    chk(result_o == exp, "R10 result hold", int'(result_o), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2048; a++) mem[a] = 12'hFFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(done_o == 0, "R1 done after reset", int'(done_o), 0);
    chk(mem_rd_o == 0, "R1 read after reset", int'(mem_rd_o), 0);
    chk(result_o == 16'h0, "R1 result after reset", int'(result_o), 0);

    // R4 blank images
    run(1'b0, 1'b0);
    chk(result_o == 16'hEE20, "R4 small blank", int'(result_o), 16'hEE20);
    run(1'b1, 1'b0);
    chk(result_o == 16'hEC20, "R4 large blank", int'(result_o), 16'hEC20);
    hold_check(16'hEC20);

    // R5/R6 protected small, only the packed IDs remain
    for (int a = 0; a < 2048; a++) mem[a] = 12'h000;
    mem[1023] = 12'hFE0;
    mem[512] = 12'hFF1; mem[513] = 12'hFF2; mem[514] = 12'hFF3; mem[515] = 12'hFF4;
    run(1'b0, 1'b0);
    chk(result_o == 16'h1234, "R6 packed ID order", int'(result_o), 16'h1234);

    // R3/R4 small unprotected pattern, top user word excluded
    for (int a = 0; a < 2048; a++) mem[a] = 12'((a * 37 + 5) & 12'hFFF);
    mem[1023] = 12'hFFF;
    mem[511]  = 12'hABC;
    run(1'b0, 1'b0);
    hold_check(ref_sum(1'b0));

    // R5/R9/R2 large protected pattern with mid-pass start and variant flip
    mem[2047] = 12'h5A7;
    run(1'b1, 1'b1);

    // R4 large unprotected pattern
    mem[2047] = 12'h3CB;
    run(1'b1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule